// File: doc/BRIEF.md
# Latched 64-bit Match Timer

A memory-mapped system timer for a 32-bit register bus. A free-running 64-bit count advances once per prescaler period. Software reads a consistent 64-bit value by writing a snapshot command and then reading two snapshot words. The snapshot words hold their value until the next command, so a carry between the two halves between the two reads cannot tear the result.

Six 32-bit compare channels watch the low word of the count. A hit sets a sticky status bit, which software clears by writing a one. Each channel has its own interrupt enable, and the interrupt line is the OR of the enabled status bits. Channel 5 can also drive a one-cycle reset request when the watchdog enable is on.

All register traffic is single-cycle: writes take effect at the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally. The block has no stream data path, so there is no valid/ready handshake and no back-pressure.

Top module: `match_timer_top`

## Requirements
- R1: After reset the count, both snapshot words, status, interrupt enables, watchdog enable and divider read 0. Every compare register reads 0xFFFFFFFF. `irq` and `wdt_rst` are low.
- R2: The count increases by 1 once every 2×(DIV+1) clocks, where DIV is the divider at byte offset 0x2C. A divider write restarts the prescaler, and the first increment after it lands 2×(DIV+1) edges after the write edge.
- R3: The count's low word (0x00) and high word (0x04) read back the live count and are writable. A write to either word replaces that word and suppresses any increment in the same cycle.
- R4: Writing 1 in bit 0 to offset 0x30 copies the whole 64-bit count, as it stood before that edge, into snapshot low (0x34) and snapshot high (0x38). The snapshot holds until the next such write. A write to 0x30 with bit 0 clear changes nothing.
- R5: An increment with the low word at 0xFFFFFFFF wraps the low word to 0 and adds 1 to the high word.
- R6: Compare register N sits at 0x08+4N. On an increment edge where the low word before the increment equals compare N, status bit N (offset 0x20, bit N) sets.
- R7: Compares are evaluated only on increment edges. A low word that equals a compare value between increments sets nothing.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A bit that sets on the same edge as its clear stays set.
- R9: `irq` is high exactly when some status bit N is set while enable bit N (offset 0x24, bits 5:0) is set. A disabled channel still sets its status bit.
- R10: When bit 0 at offset 0x28 is set, a channel-5 hit raises `wdt_rst` for exactly one cycle, in the same cycle that status bit 5 becomes set. When bit 0 is clear, `wdt_rst` stays low.
- R11: Reads of offset 0x30, of 0x3C, and of any address at or above 0x40 return 0. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | OR of enabled status bits |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest cases depend on the prescaler phase. These are a status clear that lands on the very edge where a compare hits, and a low word that sits at a compare value for many cycles before the increment edge arrives. The bench pins the phase down by writing the divider, because that write restarts the prescaler. It then counts edges from that write, so a clear can be placed exactly on the hit edge or inside the waiting window. Divider values, compare values and channels are otherwise drawn at random, with a fixed seed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int NUM_CH = 6;
  localparam int WDT_CH = 5;

  // word index = byte address bits 5:2
  localparam logic [3:0] IX_CLO   = 4'd0;
  localparam logic [3:0] IX_CHI   = 4'd1;
  localparam logic [3:0] IX_M0    = 4'd2;
  localparam logic [3:0] IX_STAT  = 4'd8;
  localparam logic [3:0] IX_IEN   = 4'd9;
  localparam logic [3:0] IX_WDEN  = 4'd10;
  localparam logic [3:0] IX_DIV   = 4'd11;
  localparam logic [3:0] IX_LATCH = 4'd12;
  localparam logic [3:0] IX_SLO   = 4'd13;
  localparam logic [3:0] IX_SHI   = 4'd14;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W:0] pcnt;

  // terminal count 2*div+1 gives a period of 2*(div+1)
  assign tick = (pcnt == {div, 1'b1}) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (restart | tick) pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter import tmr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              latch_go,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_lo | wr_hi) begin
      if (wr_lo) cnt[DATA_W-1:0]     <= wdata;
      if (wr_hi) cnt[CNT_W-1:DATA_W] <= wdata;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap <= '0;
    else if (latch_go) snap <= cnt;
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match import tmr_pkg::*; (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [DATA_W-1:0]             cnt_lo,
  input  logic [NUM_CH-1:0]             match_wr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_CH-1:0]             clr,
  output logic [NUM_CH-1:0][DATA_W-1:0] match_q,
  output logic [NUM_CH-1:0]             status,
  output logic [NUM_CH-1:0]             hit
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign hit[n] = tick && (cnt_lo == match_q[n]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           match_q[n] <= '1;
      else if (match_wr[n]) match_q[n] <= wdata;
    end

    // a new hit outranks a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[n] <= 1'b0;
      else        status[n] <= (status[n] & ~clr[n]) | hit[n];
    end
  end
endmodule

// File: rtl/match_timer_top.sv
module match_timer_top import tmr_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wdt_rst
);
  logic                          in_map, wr_ok;
  logic [3:0]                    widx;
  logic                          wr_lo, wr_hi, cnt_wr, latch_go, div_wr;
  logic [NUM_CH-1:0]             mwr, clr_mask, status, hit, ien;
  logic                          wden;
  logic [DIV_W-1:0]              div_q;
  logic                          tick;
  logic [CNT_W-1:0]              cnt, snap;
  logic [NUM_CH-1:0][DATA_W-1:0] match_q;
  logic                          unused_lsb;

  assign unused_lsb = ^bus_addr[1:0];
  assign in_map   = (bus_addr >> 6) == '0;
  assign widx     = bus_addr[5:2];
  assign wr_ok    = bus_wr & in_map;
  assign wr_lo    = wr_ok && (widx == IX_CLO);
  assign wr_hi    = wr_ok && (widx == IX_CHI);
  assign cnt_wr   = wr_lo | wr_hi;
  assign latch_go = wr_ok && (widx == IX_LATCH) && bus_wdata[0];
  assign div_wr   = wr_ok && (widx == IX_DIV);
  assign clr_mask = (wr_ok && (widx == IX_STAT)) ? bus_wdata[NUM_CH-1:0] : '0;

  always_comb begin
    for (int n = 0; n < NUM_CH; n++)
      mwr[n] = wr_ok && (widx == IX_M0 + 4'(n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien   <= '0;
      wden  <= 1'b0;
      div_q <= '0;
    end else begin
      if (wr_ok && (widx == IX_IEN))  ien  <= bus_wdata[NUM_CH-1:0];
      if (wr_ok && (widx == IX_WDEN)) wden <= bus_wdata[0];
      if (div_wr)                     div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div(div_q), .restart(div_wr), .tick(tick)
  );

  tmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .latch_go(latch_go), .cnt(cnt), .snap(snap)
  );

  tmr_match u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_lo(cnt[DATA_W-1:0]),
    .match_wr(mwr), .wdata(bus_wdata), .clr(clr_mask),
    .match_q(match_q), .status(status), .hit(hit)
  );

  assign irq = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_rst <= 1'b0;
    else        wdt_rst <= hit[WDT_CH] & wden;
  end

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      for (int n = 0; n < NUM_CH; n++)
        if (widx == IX_M0 + 4'(n)) bus_rdata = match_q[n];
      case (widx)
        IX_CLO:  bus_rdata = cnt[DATA_W-1:0];
        IX_CHI:  bus_rdata = cnt[CNT_W-1:DATA_W];
        IX_STAT: bus_rdata = DATA_W'(status);
        IX_IEN:  bus_rdata = DATA_W'(ien);
        IX_WDEN: bus_rdata = DATA_W'(wden);
        IX_DIV:  bus_rdata = DATA_W'(div_q);
        IX_SLO:  bus_rdata = snap[DATA_W-1:0];
        IX_SHI:  bus_rdata = snap[CNT_W-1:DATA_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk import tmr_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cnt_wr,
  input logic              latch_go,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  snap,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] clr,
  input logic              wdt_rst
);
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(cnt_wr)) |-> $stable(cnt));

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(latch_go) |-> $stable(snap));

  // R7
  stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) != '0) |-> $past(tick));

  // R8
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status & $past(status) & ~$past(clr)) == '0));

  // R10
  wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  // R10
  wdt_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> status[WDT_CH]);
endmodule

bind match_timer_top tmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
  .latch_go(latch_go), .cnt(cnt), .snap(snap), .status(status),
  .clr(clr_mask), .wdt_rst(wdt_rst)
);

// File: tb/tb_match_timer_top.sv
module tb_match_timer_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wdt_rst;
  int          nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdt_rst(wdt_rst)
  );

  function automatic int period(int d); return 2 * (d + 1); endfunction
  function automatic int hit_edge(int x, int d); return (x + 1) * period(d); endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // called at a negedge; write edge is the next posedge; returns at the following negedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(8'h34, lo); rd(8'h38, hi); v = {hi, lo};
  endtask

  // directed/random compare channel run; phase anchored by the divider write
  task automatic run_match(int ch, int d, int x, bit ie_on, bit wd_on);
    logic [31:0] v;
    int t = hit_edge(x, d);
    wr(8'h08 + 8'(4 * ch), 32'(x));
    wr(8'h24, 32'(ie_on) << ch);
    wr(8'h28, 32'(wd_on));
    wr(8'h00, 0);
    wr(8'h04, 0);
    wr(8'h2C, 32'(d));        // edge E
    wr(8'h20, 32'h3F);        // edge E+1
    idle(t - 2);              // E+t-0.5
    rd(8'h20, v);
    chk("R6 status before hit", 64'(v[ch]), 0);
    chk("R9 irq before hit", 64'(irq), 0);
    chk("R10 wdt before hit", 64'(wdt_rst), 0);
    idle(1);                  // E+t+0.5
    rd(8'h20, v);
    chk("R6 status after hit", 64'(v[ch]), 1);
    chk("R9 irq after hit", 64'(irq), 64'(ie_on));
    chk("R10 wdt at hit", 64'(wdt_rst), 64'(wd_on && ch == 5));
    idle(1);
    chk("R10 wdt one cycle", 64'(wdt_rst), 0);
    wr(8'h28, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v, h, w;
    logic [63:0] a, b;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 count lo", 64'(v), 0);
    rd(8'h04, v); chk("R1 count hi", 64'(v), 0);
    rd(8'h20, v); chk("R1 status", 64'(v), 0);
    rd(8'h24, v); chk("R1 ien", 64'(v), 0);
    rd(8'h28, v); chk("R1 wden", 64'(v), 0);
    rd(8'h2C, v); chk("R1 div", 64'(v), 0);
    snap64(a);    chk("R1 snapshot", a, 0);
    for (int n = 0; n < 6; n++) begin
      rd(8'h08 + 8'(4 * n), v); chk("R1 match", 64'(v), 64'hFFFF_FFFF);
    end
    chk("R1 irq", 64'(irq), 0);
    chk("R1 wdt", 64'(wdt_rst), 0);

    // R3 write wins over an increment on the same edge
    w = $urandom; h = $urandom;
    wr(8'h2C, 0);             // E, tick due at E+2
    wr(8'h00, w);             // E+1
    wr(8'h04, h);             // E+2, tick suppressed
    rd(8'h00, v); chk("R3 lo held on write edge", 64'(v), 64'(w));
    rd(8'h04, v); chk("R3 hi written", 64'(v), 64'(h));

    // R4/R5 snapshot coherency and carry
    h = $urandom & 32'h7FFF_FFFF;
    wr(8'h2C, 100);           // E
    wr(8'h04, h);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h30, 1);             // E+3
    snap64(a); chk("R4 snapshot taken", a, {h, 32'hFFFF_FFFF});
    idle(202);                // E+205.5, increment at E+202
    snap64(a); chk("R4 snapshot held", a, {h, 32'hFFFF_FFFF});
    rd(8'h04, v); chk("R5 carry into hi", 64'(v), 64'(h + 1));
    wr(8'h30, 0);
    snap64(a); chk("R4 latch bit0 clear ignored", a, {h, 32'hFFFF_FFFF});
    wr(8'h30, 1);
    snap64(a); chk("R5 snapshot after carry", a, {h + 32'd1, 32'h0});

    // R2 rate, phase independent over a whole number of periods
    for (int i = 0; i < 4; i++) begin
      int d = int'($urandom % 8);
      int k = 3 + int'($urandom % 8);
      wr(8'h2C, 32'(d));
      wr(8'h30, 1); snap64(a);
      idle(k * period(d) - 1);
      wr(8'h30, 1); snap64(b);
      chk("R2 increments per window", b - a, 64'(k));
    end

    // R6/R9/R10 random channels
    for (int i = 0; i < 10; i++) begin
      int ch = int'($urandom % 6);
      run_match(ch, int'($urandom % 4), 1 + int'($urandom % 12),
                1'($urandom), (ch == 5) ? 1'($urandom) : 1'b0);
    end
    run_match(5, 1, 4, 1'b1, 1'b1);   // R10 watchdog on
    run_match(5, 0, 3, 1'b0, 1'b0);   // R10 off, R9 silent channel

    // R8 set wins over a same-edge clear
    begin
      int t = hit_edge(5, 2);
      wr(8'h14, 5);            // channel 3
      wr(8'h24, 32'h8);
      wr(8'h00, 0); wr(8'h04, 0);
      wr(8'h2C, 2);            // E
      wr(8'h20, 32'h3F);       // E+1
      idle(t - 2);
      wr(8'h20, 32'h8);        // lands on E+t, the hit edge
      rd(8'h20, v); chk("R8 set beats clear", 64'(v[3]), 1);
      wr(8'h20, 0);
      rd(8'h20, v); chk("R8 zero write no effect", 64'(v[3]), 1);
      chk("R9 irq enabled", 64'(irq), 1);
      wr(8'h20, 32'h8);
      rd(8'h20, v); chk("R8 one clears", 64'(v[3]), 0);
      chk("R9 irq after clear", 64'(irq), 0);
    end

    // R7 equal low word between increments sets nothing
    wr(8'h0C, 32'd77);         // channel 1
    wr(8'h2C, 9);              // E, period 20
    wr(8'h00, 77);             // E+1
    wr(8'h20, 32'h3F);         // E+2
    wr(8'h20, 32'h3F);         // E+3
    rd(8'h20, v); chk("R7 no set between ticks", 64'(v[1]), 0);
    idle(16);                  // E+19.5
    rd(8'h20, v); chk("R7 still clear before tick", 64'(v[1]), 0);
    idle(1);                   // E+20.5
    rd(8'h20, v); chk("R7 set on tick", 64'(v[1]), 1);

    // R11 reads that return zero, low address bits ignored
    wr(8'h24, 32'h2A);
    rd(8'h26, v); chk("R11 low bits ignored", 64'(v), 64'h2A);
    rd(8'h30, v); chk("R11 latch reads zero", 64'(v), 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h3C | 8'($urandom % 4), v); chk("R11 hole reads zero", 64'(v), 0);
      rd(8'h40 + 8'($urandom % 192), v); chk("R11 high addr reads zero", 64'(v), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule